// File: doc/BRIEF.md
# Warn/Acknowledge Virtual-Wire Responder

This block answers, without firmware help, the warning virtual wires that a host controller raises toward a management device. Three warnings are served: suspend, host reset and out-of-band reset. Each is answered with its own acknowledge wire. An acknowledge is raised only when the detection strobe for that warning arrives while the warning wire still reads high. The two reset acknowledges also wait for a quiesce-done input. That input stands in for the flushing of the matching upstream request queues.

The block also owns the two boot wires, boot-load-done and boot-load-status. When a link hardware reset is reported, it pulls a multi-bit soft-reset field low for a minimum number of cycles and then releases it. After that it re-runs the boot check and re-acknowledges a suspend warning that is still pending. Serialising the wires onto the link is handled elsewhere.

Top module: `vwr_responder`

## Requirements
- R1: While `rst` is high, every acknowledge and both boot wires read 0 and `soft_rst_o` reads all ones.
- R2: In the first cycle after reset is released, with `full_off_i` low, `boot_done_o` and `boot_ok_o` rise together, one clock edge after the first edge with `rst` low. They always hold equal values.
- R3: `sus_ack_o` rises one edge after an edge where `sus_evt_i` and `sus_warn_i` are both high. A strobe with the warning low is ignored, and a high warning without a strobe raises nothing.
- R4: When a strobe on `hrst_evt_i` arrives with `hrst_warn_i` high, `hrst_ack_o` rises on that edge if `periph_quiet_i` is high. Otherwise the acknowledge is held pending and rises on the first later edge that samples `periph_quiet_i` high. Dropping the quiesce input afterwards does not clear it.
- R5: `oob_ack_o` follows the same rule as R4, using `oob_warn_i`, `oob_evt_i` and `oob_quiet_i`.
- R6: An acknowledge clears one edge after its warning wire is sampled low. A pending acknowledge is dropped at the same time, so it does not later rise without a new strobe.
- R7: On the edge that samples `link_rst_i` high, `soft_rst_o` goes to all zeros. It stays there for `LOW_CYC` cycles (default 2, never fewer than 2) and then returns to all ones. Every bit of the field moves together.
- R8: One edge after `soft_rst_o` returns to all ones, the boot check runs: both boot wires are set if boot-load-status is clear and `full_off_i` is low. On the same edge, `sus_ack_o` is raised if `sus_warn_i` is high and the acknowledge is not already set.
- R9: One edge after `full_off_i` is sampled high, both boot wires clear. They stay clear while it is held, and no boot check sets them. They are set again only by the next boot check after `full_off_i` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sus_warn_i | input | 1 | Decoded suspend warning level |
| sus_evt_i | input | 1 | Suspend warning rising-edge strobe |
| hrst_warn_i | input | 1 | Decoded host-reset warning level |
| hrst_evt_i | input | 1 | Host-reset warning change strobe |
| oob_warn_i | input | 1 | Decoded out-of-band reset warning level |
| oob_evt_i | input | 1 | Out-of-band reset warning change strobe |
| periph_quiet_i | input | 1 | Peripheral upstream queues quiesced |
| oob_quiet_i | input | 1 | Out-of-band upstream queues quiesced |
| link_rst_i | input | 1 | Link hardware reset strobe |
| full_off_i | input | 1 | System is in the fully-off state |
| sus_ack_o | output | 1 | Suspend acknowledge wire |
| hrst_ack_o | output | 1 | Host-reset acknowledge wire |
| oob_ack_o | output | 1 | Out-of-band reset acknowledge wire |
| boot_done_o | output | 1 | Boot-load-done wire |
| boot_ok_o | output | 1 | Boot-load-status wire |
| soft_rst_o | output | SR_W | Soft-reset control field, active low |

## Verification
The properties assume that the warning levels and strobes come from an upstream decoder and change only between clock edges. They also assume that a strobe reflects a real transition, so an acknowledge is never expected without a warning level that was high on the previous edge. The stimulus changes every input only on the falling clock edge. It raises strobes for single cycles, and it toggles the quiesce inputs only while a warning is present or pending. This keeps the checks on acknowledge ordering within that decoded-wire contract.

// File: rtl/vwr_pkg.sv
package vwr_pkg;
  typedef enum logic [1:0] {SEQ_IDLE, SEQ_LOW, SEQ_CHECK} seq_st_t;
  typedef enum logic [1:0] {ACK_OFF, ACK_WAIT, ACK_ON} ack_st_t;
endpackage

// File: rtl/vwr_ack_chan.sv
module vwr_ack_chan #(
  parameter bit GATED = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic warn_i,
  input  logic evt_i,
  input  logic quiet_i,
  input  logic rearm_i,
  output logic ack_o
);
  import vwr_pkg::*;

  ack_st_t st;
  logic    ok_now;

  // an ungated channel never waits for a quiesce report
  assign ok_now = quiet_i || !GATED;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ACK_OFF;
    end else if (!warn_i) begin
      st <= ACK_OFF;
    end else begin
      case (st)
        ACK_OFF:  if (evt_i || rearm_i) st <= ok_now ? ACK_ON : ACK_WAIT;
        ACK_WAIT: if (ok_now) st <= ACK_ON;
        default:  st <= st;
      endcase
    end
  end

  assign ack_o = (st == ACK_ON);
endmodule

// File: rtl/vwr_link_seq.sv
module vwr_link_seq #(
  parameter int SR_W    = 8,
  parameter int LOW_CYC = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            link_rst_i,
  input  logic            full_off_i,
  output logic [SR_W-1:0] soft_rst_o,
  output logic            boot_done_o,
  output logic            boot_ok_o,
  output logic            rearm_o
);
  import vwr_pkg::*;

  localparam int LOW_N = (LOW_CYC < 2) ? 2 : LOW_CYC;
  localparam int CNT_W = $clog2(LOW_N + 1);

  seq_st_t    st;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= SEQ_CHECK;
      cnt         <= '0;
      soft_rst_o  <= '1;
      boot_done_o <= 1'b0;
      boot_ok_o   <= 1'b0;
    end else begin
      if (link_rst_i) begin
        st         <= SEQ_LOW;
        cnt        <= CNT_W'(LOW_N - 1);
        soft_rst_o <= '0;
      end else begin
        case (st)
          SEQ_LOW: begin
            if (cnt == '0) begin
              soft_rst_o <= '1;
              st         <= SEQ_CHECK;
            end else begin
              cnt <= cnt - 1'b1;
            end
          end
          SEQ_CHECK: begin
            st <= SEQ_IDLE;
            if (!boot_ok_o && !full_off_i) begin
              boot_done_o <= 1'b1;
              boot_ok_o   <= 1'b1;
            end
          end
          default: st <= SEQ_IDLE;
        endcase
      end
      if (full_off_i) begin
        boot_done_o <= 1'b0;
        boot_ok_o   <= 1'b0;
      end
    end
  end

  assign rearm_o = (st == SEQ_CHECK) && !link_rst_i;
endmodule

// File: rtl/vwr_responder.sv
module vwr_responder #(
  parameter int SR_W    = 8,
  parameter int LOW_CYC = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sus_warn_i,
  input  logic            sus_evt_i,
  input  logic            hrst_warn_i,
  input  logic            hrst_evt_i,
  input  logic            oob_warn_i,
  input  logic            oob_evt_i,
  input  logic            periph_quiet_i,
  input  logic            oob_quiet_i,
  input  logic            link_rst_i,
  input  logic            full_off_i,
  output logic            sus_ack_o,
  output logic            hrst_ack_o,
  output logic            oob_ack_o,
  output logic            boot_done_o,
  output logic            boot_ok_o,
  output logic [SR_W-1:0] soft_rst_o
);
  localparam int         NCH       = 3;
  // channel 0 suspend, 1 host reset, 2 out-of-band reset
  localparam logic [NCH-1:0] GATE_MASK = 3'b110;

  logic [NCH-1:0] warn_v, evt_v, quiet_v, rearm_v, ack_v;
  logic           seq_rearm;

  assign warn_v  = {oob_warn_i, hrst_warn_i, sus_warn_i};
  assign evt_v   = {oob_evt_i, hrst_evt_i, sus_evt_i};
  assign quiet_v = {oob_quiet_i, periph_quiet_i, 1'b1};
  assign rearm_v = {1'b0, 1'b0, seq_rearm};

  vwr_link_seq #(.SR_W(SR_W), .LOW_CYC(LOW_CYC)) seq_i (
    .clk         (clk),
    .rst         (rst),
    .link_rst_i  (link_rst_i),
    .full_off_i  (full_off_i),
    .soft_rst_o  (soft_rst_o),
    .boot_done_o (boot_done_o),
    .boot_ok_o   (boot_ok_o),
    .rearm_o     (seq_rearm)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    vwr_ack_chan #(.GATED(GATE_MASK[g])) chan_i (
      .clk     (clk),
      .rst     (rst),
      .warn_i  (warn_v[g]),
      .evt_i   (evt_v[g]),
      .quiet_i (quiet_v[g]),
      .rearm_i (rearm_v[g]),
      .ack_o   (ack_v[g])
    );
  end

  assign sus_ack_o  = ack_v[0];
  assign hrst_ack_o = ack_v[1];
  assign oob_ack_o  = ack_v[2];
endmodule

// File: rtl/vwr_responder_chk.sv
module vwr_responder_chk #(
  parameter int SR_W = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            sus_warn_i,
  input logic            hrst_warn_i,
  input logic            oob_warn_i,
  input logic            periph_quiet_i,
  input logic            oob_quiet_i,
  input logic            full_off_i,
  input logic            sus_ack_o,
  input logic            hrst_ack_o,
  input logic            oob_ack_o,
  input logic            boot_done_o,
  input logic            boot_ok_o,
  input logic [SR_W-1:0] soft_rst_o
);
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (!sus_ack_o && !hrst_ack_o && !oob_ack_o && !boot_done_o &&
             soft_rst_o == {SR_W{1'b1}}));

  a_r2_boot_pair: assert property (@(posedge clk) disable iff (rst)
    boot_done_o == boot_ok_o);

  a_r4_hrst_after_quiet: assert property (@(posedge clk) disable iff (rst)
    $rose(hrst_ack_o) |-> $past(periph_quiet_i));

  a_r5_oob_after_quiet: assert property (@(posedge clk) disable iff (rst)
    $rose(oob_ack_o) |-> $past(oob_quiet_i));

  a_r6_ack_needs_warn: assert property (@(posedge clk) disable iff (rst)
    (sus_ack_o || hrst_ack_o || oob_ack_o) |->
      ((!sus_ack_o || $past(sus_warn_i)) && (!hrst_ack_o || $past(hrst_warn_i)) &&
       (!oob_ack_o || $past(oob_warn_i))));

  a_r7_field_whole: assert property (@(posedge clk) disable iff (rst)
    (soft_rst_o == {SR_W{1'b0}}) || (soft_rst_o == {SR_W{1'b1}}));

  a_r7_low_min: assert property (@(posedge clk) disable iff (rst)
    $fell(soft_rst_o[0]) |=> !soft_rst_o[0]);

  a_r9_off_clears: assert property (@(posedge clk) disable iff (rst)
    $past(full_off_i) |-> !boot_done_o);
endmodule

bind vwr_responder vwr_responder_chk #(.SR_W(SR_W)) chk_i (
  .clk            (clk),
  .rst            (rst),
  .sus_warn_i     (sus_warn_i),
  .hrst_warn_i    (hrst_warn_i),
  .oob_warn_i     (oob_warn_i),
  .periph_quiet_i (periph_quiet_i),
  .oob_quiet_i    (oob_quiet_i),
  .full_off_i     (full_off_i),
  .sus_ack_o      (sus_ack_o),
  .hrst_ack_o     (hrst_ack_o),
  .oob_ack_o      (oob_ack_o),
  .boot_done_o    (boot_done_o),
  .boot_ok_o      (boot_ok_o),
  .soft_rst_o     (soft_rst_o)
);

// File: tb/vwr_responder_tb_top.sv
module vwr_responder_tb_top;
  localparam int SR_W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sus_warn = 0, sus_evt = 0, hrst_warn = 0, hrst_evt = 0;
  logic oob_warn = 0, oob_evt = 0, periph_quiet = 0, oob_quiet = 0;
  logic link_rst = 0, full_off = 0;
  logic sus_ack, hrst_ack, oob_ack, boot_done, boot_ok;
  logic [SR_W-1:0] soft_rst;

  always #10 clk = ~clk;

  vwr_responder #(.SR_W(SR_W), .LOW_CYC(2)) dut_i (
    .clk(clk), .rst(rst),
    .sus_warn_i(sus_warn), .sus_evt_i(sus_evt),
    .hrst_warn_i(hrst_warn), .hrst_evt_i(hrst_evt),
    .oob_warn_i(oob_warn), .oob_evt_i(oob_evt),
    .periph_quiet_i(periph_quiet), .oob_quiet_i(oob_quiet),
    .link_rst_i(link_rst), .full_off_i(full_off),
    .sus_ack_o(sus_ack), .hrst_ack_o(hrst_ack), .oob_ack_o(oob_ack),
    .boot_done_o(boot_done), .boot_ok_o(boot_ok), .soft_rst_o(soft_rst)
  );

  typedef struct {
    int unsigned    at;
    logic [12:0]    v;
    string          tag;
  } exp_t;

  exp_t        sb[$];
  int unsigned cyc = 0;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // layout {sus, hrst, oob, done, status, soft[7:0]}
  function automatic logic [12:0] ev(bit s, bit h, bit o, bit b, bit low);
    return {s, h, o, b, b, (low ? 8'h00 : 8'hFF)};
  endfunction

  task automatic expect_in(int n, logic [12:0] v, string tag);
    exp_t e;
    e.at = cyc + n; e.v = v; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: compare results on falling edges
  always @(negedge clk) begin
    logic [12:0] got;
    got = {sus_ack, hrst_ack, oob_ack, boot_done, boot_ok, soft_rst};
    while (sb.size() > 0 && sb[0].at <= cyc) begin
      exp_t e;
      e = sb.pop_front();
      n_chk++;
      if (got !== e.v) begin
        n_bad++;
        $display("FAIL %s: got %h expected %h", e.tag, got, e.v);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    step(1);
    expect_in(1, ev(0,0,0,0,0), "R1 reset state");
    step(2);
    rst = 0;
    expect_in(1, ev(0,0,0,1,0), "R2 boot wires after reset");
    step(2);

    // R3 suspend
    sus_warn = 1;
    expect_in(1, ev(0,0,0,1,0), "R3 no strobe no ack");
    step(1);
    sus_evt = 1;
    expect_in(1, ev(1,0,0,1,0), "R3 ack on strobe");
    step(1); sus_evt = 0;
    sus_warn = 0;
    expect_in(1, ev(0,0,0,1,0), "R6 suspend ack clears");
    step(1);
    sus_evt = 1;
    expect_in(1, ev(0,0,0,1,0), "R3 strobe with warn low ignored");
    step(1); sus_evt = 0;
    expect_in(1, ev(0,0,0,1,0), "R3 still idle");
    step(1);

    // R4 host reset with quiesce gate
    hrst_warn = 1; hrst_evt = 1;
    expect_in(1, ev(0,0,0,1,0), "R4 held without quiesce");
    step(1); hrst_evt = 0;
    expect_in(2, ev(0,0,0,1,0), "R4 still pending");
    step(2);
    periph_quiet = 1;
    expect_in(1, ev(0,1,0,1,0), "R4 ack after quiesce");
    step(1);
    periph_quiet = 0;
    expect_in(1, ev(0,1,0,1,0), "R4 ack holds");
    step(1);
    hrst_warn = 0;
    expect_in(1, ev(0,0,0,1,0), "R6 host ack clears");
    step(1);
    periph_quiet = 1; hrst_warn = 1; hrst_evt = 1;
    expect_in(1, ev(0,1,0,1,0), "R4 immediate ack");
    step(1);
    hrst_evt = 0; hrst_warn = 0; periph_quiet = 0;
    expect_in(1, ev(0,0,0,1,0), "R6 host ack clears again");
    step(1);

    // R5 / R6 out-of-band
    oob_warn = 1; oob_evt = 1;
    expect_in(1, ev(0,0,0,1,0), "R5 held without quiesce");
    step(1); oob_evt = 0; oob_warn = 0;
    step(1);
    oob_quiet = 1; oob_warn = 1;
    expect_in(1, ev(0,0,0,1,0), "R6 pending dropped");
    expect_in(2, ev(0,0,0,1,0), "R6 pending stays dropped");
    step(2);
    oob_evt = 1;
    expect_in(1, ev(0,0,1,1,0), "R5 ack with quiesce");
    step(1);
    oob_evt = 0; oob_warn = 0; oob_quiet = 0;
    expect_in(1, ev(0,0,0,1,0), "R6 oob ack clears");
    step(1);

    // R7 / R8 link reset with pending suspend warning
    sus_warn = 1; link_rst = 1;
    expect_in(1, ev(0,0,0,1,1), "R7 field low");
    expect_in(2, ev(0,0,0,1,1), "R7 field low second cycle");
    expect_in(3, ev(0,0,0,1,0), "R7 field restored");
    expect_in(4, ev(1,0,0,1,0), "R8 suspend re-ack");
    step(1); link_rst = 0;
    step(3);
    sus_warn = 0;
    expect_in(1, ev(0,0,0,1,0), "R6 suspend clears after re-ack");
    step(1);

    // R9 fully-off
    full_off = 1;
    expect_in(1, ev(0,0,0,0,0), "R9 boot wires cleared");
    step(1);
    link_rst = 1;
    expect_in(1, ev(0,0,0,0,1), "R7 field low while off");
    expect_in(4, ev(0,0,0,0,0), "R9 no boot set while off");
    step(1); link_rst = 0;
    step(3);
    full_off = 0;
    expect_in(1, ev(0,0,0,0,0), "R9 stays clear after off ends");
    step(1);
    link_rst = 1;
    expect_in(3, ev(0,0,0,0,0), "R8 before boot check");
    expect_in(4, ev(0,0,0,1,0), "R8 boot check sets wires");
    step(1); link_rst = 0;
    step(5);

    if (sb.size() != 0) begin
      n_chk++; n_bad++;
      $display("FAIL scoreboard: got %0d left expected 0", sb.size());
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule